// File: doc/BRIEF.md
# Rotating Priority and End-of-Interrupt Unit

This block keeps track of which of eight interrupt levels are being serviced and decides which pending level, if any, may interrupt the processor next. It holds the in-service bits and a pointer to the lowest-priority level. The level just above that pointer, wrapping from 7 to 0, has the highest priority. A host-side decoder passes the block a one-cycle command strobe with a 3-bit command code and a 3-bit level. The block uses these commands to close out service (end of interrupt, EOI) and to move the priority pointer.

The pending requests arrive already masked. The block picks the winning level under the current rotation and raises its request output only when that level outranks everything in service, which gives fully nested behaviour. An acknowledge pulse moves the winner into service. When the automatic-EOI configuration input is high, the winner is not kept in service. A two-state mode machine records whether an acknowledge in automatic-EOI operation also rotates priority. It has two states: `MODE_PLAIN` (no rotation on automatic EOI) and `MODE_ROTATE` (the acknowledged level becomes the lowest). It moves from `MODE_PLAIN` to `MODE_ROTATE` on command code 100 and back on command code 000. Every other input leaves the state where it is.

Top module: `prio_eoi_unit`

## Requirements
- R1: Reset clears every in-service bit, sets the lowest-priority pointer to level 7 (so level 0 is highest), and puts the mode machine in `MODE_PLAIN`.
- R2: `win_level_o` is the set bit of `req_i` that comes first when counting up from (lowest + 1) mod 8, wrapping. It is 0 when no request is set.
- R3: `irq_o` is high exactly when some request is set and the winning level is strictly higher in priority than every set in-service bit. It is combinational from `req_i` and the registered state.
- R4: An acknowledge (`ack_i` high) while `irq_o` is high and `cmd_valid_i` is low sets the in-service bit of `win_level_o` at the next clock edge, provided `auto_eoi_i` is low. An acknowledge while `irq_o` is low, or in the same cycle as a command strobe, changes nothing.
- R5: With `auto_eoi_i` high, an accepted acknowledge leaves the in-service bits unchanged. In `MODE_ROTATE` it also makes the acknowledged level the lowest priority; in `MODE_PLAIN` the pointer stays where it is.
- R6: Command code 100 selects `MODE_ROTATE` and code 000 selects `MODE_PLAIN`. Code 010 changes no state.
- R7: Command code 001 clears the in-service bit with the highest priority under the current rotation. With nothing in service it has no effect.
- R8: Command code 011 clears the in-service bit named by `cmd_level_i`. If that bit is not set, it has no effect.
- R9: Command code 101 clears the highest-priority in-service bit and makes that level the lowest priority. With nothing in service, neither the bits nor the pointer change.
- R10: Command code 110 makes `cmd_level_i` the lowest priority and leaves the in-service bits alone.
- R11: Command code 111 clears the in-service bit named by `cmd_level_i` and makes that level the lowest priority.
- R12: Every command and acknowledge takes effect at the first rising clock edge after it is presented. `isr_o`, `win_level_o` and `irq_o` reflect the new state straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Masked pending requests, one bit per level |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| auto_eoi_i | input | 1 | Automatic-EOI configuration |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_code_i | input | 3 | Command code: 000 rotate-mode off, 001 EOI, 010 no-op, 011 specific EOI, 100 rotate-mode on, 101 rotating EOI, 110 set priority, 111 rotating specific EOI |
| cmd_level_i | input | 3 | Level operand of the command |
| win_level_o | output | 3 | Highest-priority pending level |
| irq_o | output | 1 | Interrupt request to the processor |
| isr_o | output | 8 | In-service bits |

## Verification
The registered state (`isr_o` and the priority pointer seen through `win_level_o`) changes one edge after a strobe or acknowledge. The bench therefore holds each stimulus across one rising edge and samples 1 ns after it, with the inputs still applied. `irq_o` and `win_level_o` are combinational from `req_i`, so the same sample shows them against the updated state with no extra cycle. Pointer moves are never read directly: they are observed through the winner that a fixed request pattern produces after each command.

// File: rtl/prio_eoi_pkg.sv
package prio_eoi_pkg;

    localparam int NUM_LEVELS = 8;
    localparam int LVL_W      = $clog2(NUM_LEVELS);

    typedef enum logic [2:0] {
        CMD_ROT_AEOI_OFF = 3'b000,
        CMD_EOI          = 3'b001,
        CMD_NOP          = 3'b010,
        CMD_SPEC_EOI     = 3'b011,
        CMD_ROT_AEOI_ON  = 3'b100,
        CMD_ROT_EOI      = 3'b101,
        CMD_SET_PRIO     = 3'b110,
        CMD_ROT_SPEC_EOI = 3'b111
    } cmd_code_t;

    typedef enum logic {
        MODE_PLAIN  = 1'b0,
        MODE_ROTATE = 1'b1
    } rot_mode_t;

endpackage

// File: rtl/prio_rot_arbiter.sv
module prio_rot_arbiter #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] top_i,
    output logic         any_o,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rank_o
);

    always_comb begin
        any_o   = 1'b0;
        level_o = '0;
        rank_o  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(top_i) + k) % N;
            if (vec_i[idx]) begin
                any_o   = 1'b1;
                level_o = W'(idx);
                rank_o  = W'(k);
            end
        end
    end

endmodule

// File: rtl/prio_mode_fsm.sv
module prio_mode_fsm
    import prio_eoi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_code_i,
    output logic       rot_aeoi_o
);

    rot_mode_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_valid_i) begin
            unique case (cmd_code_t'(cmd_code_i))
                CMD_ROT_AEOI_ON:  state_d = MODE_ROTATE;
                CMD_ROT_AEOI_OFF: state_d = MODE_PLAIN;
                default:          state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_PLAIN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            MODE_ROTATE: rot_aeoi_o = 1'b1;
            default:     rot_aeoi_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/prio_isr_core.sv
module prio_isr_core
    import prio_eoi_pkg::*;
#(
    parameter int N = NUM_LEVELS,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_i,
    input  logic         irq_i,
    input  logic         auto_eoi_i,
    input  logic         rot_aeoi_i,
    input  logic         cmd_valid_i,
    input  logic [2:0]   cmd_code_i,
    input  logic [W-1:0] cmd_level_i,
    input  logic [W-1:0] win_level_i,
    input  logic         isr_any_i,
    input  logic [W-1:0] isr_top_i,
    output logic [N-1:0] isr_o,
    output logic [W-1:0] low_o
);

    localparam logic [W-1:0] LOW_RESET = W'(N - 1);

    logic [N-1:0] isr_q, isr_d;
    logic [W-1:0] low_q, low_d;
    logic         take_ack;

    assign take_ack = ack_i && irq_i && !cmd_valid_i;

    always_comb begin
        isr_d = isr_q;
        low_d = low_q;
        if (cmd_valid_i) begin
            unique case (cmd_code_t'(cmd_code_i))
                CMD_EOI: begin
                    if (isr_any_i) isr_d[isr_top_i] = 1'b0;
                end
                CMD_ROT_EOI: begin
                    if (isr_any_i) begin
                        isr_d[isr_top_i] = 1'b0;
                        low_d            = isr_top_i;
                    end
                end
                CMD_SPEC_EOI: begin
                    isr_d[cmd_level_i] = 1'b0;
                end
                CMD_ROT_SPEC_EOI: begin
                    isr_d[cmd_level_i] = 1'b0;
                    low_d              = cmd_level_i;
                end
                CMD_SET_PRIO: begin
                    low_d = cmd_level_i;
                end
                default: begin
                    isr_d = isr_q;
                end
            endcase
        end else if (take_ack) begin
            if (!auto_eoi_i) begin
                isr_d[win_level_i] = 1'b1;
            end else if (rot_aeoi_i) begin
                low_d = win_level_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
            low_q <= LOW_RESET;
        end else begin
            isr_q <= isr_d;
            low_q <= low_d;
        end
    end

    assign isr_o = isr_q;
    assign low_o = low_q;

endmodule

// File: rtl/prio_eoi_unit.sv
module prio_eoi_unit
    import prio_eoi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       req_i,
    input  logic             ack_i,
    input  logic             auto_eoi_i,
    input  logic             cmd_valid_i,
    input  logic [2:0]       cmd_code_i,
    input  logic [2:0]       cmd_level_i,
    output logic [2:0]       win_level_o,
    output logic             irq_o,
    output logic [7:0]       isr_o
);

    localparam int N = NUM_LEVELS;
    localparam int W = LVL_W;

    logic [W-1:0] low_lvl;
    logic [W-1:0] top_lvl;
    logic         rot_aeoi;
    logic         req_any, isr_any;
    logic [W-1:0] req_lvl, req_rank;
    logic [W-1:0] isr_lvl, isr_rank;
    logic [N-1:0] isr_bits;

    assign top_lvl = W'((int'(low_lvl) + 1) % N);

    prio_rot_arbiter #(.N(N), .W(W)) u_req_arb (
        .vec_i   (req_i),
        .top_i   (top_lvl),
        .any_o   (req_any),
        .level_o (req_lvl),
        .rank_o  (req_rank)
    );

    prio_rot_arbiter #(.N(N), .W(W)) u_isr_arb (
        .vec_i   (isr_bits),
        .top_i   (top_lvl),
        .any_o   (isr_any),
        .level_o (isr_lvl),
        .rank_o  (isr_rank)
    );

    assign irq_o       = req_any && (!isr_any || (req_rank < isr_rank));
    assign win_level_o = req_lvl;
    assign isr_o       = isr_bits;

    prio_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_code_i  (cmd_code_i),
        .rot_aeoi_o  (rot_aeoi)
    );

    prio_isr_core #(.N(N), .W(W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .irq_i       (irq_o),
        .auto_eoi_i  (auto_eoi_i),
        .rot_aeoi_i  (rot_aeoi),
        .cmd_valid_i (cmd_valid_i),
        .cmd_code_i  (cmd_code_i),
        .cmd_level_i (cmd_level_i),
        .win_level_i (req_lvl),
        .isr_any_i   (isr_any),
        .isr_top_i   (isr_lvl),
        .isr_o       (isr_bits),
        .low_o       (low_lvl)
    );

endmodule

// File: rtl/prio_eoi_unit_chk.sv
module prio_eoi_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] req_i,
    input logic       ack_i,
    input logic       auto_eoi_i,
    input logic       cmd_valid_i,
    input logic [2:0] cmd_code_i,
    input logic [2:0] cmd_level_i,
    input logic [2:0] win_level_o,
    input logic       irq_o,
    input logic [7:0] isr_o
);

    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_i != 8'h00));  // R3

    AST_IRQ_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> req_i[win_level_o]);  // R2

    AST_IRQ_WIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !isr_o[win_level_o]);  // R3

    AST_ISR_SET_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o && !cmd_valid_i && !auto_eoi_i)
        |=> ((isr_o & ~$past(isr_o)) == 8'h00));  // R4

    AST_ACK_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !cmd_valid_i && !auto_eoi_i)
        |=> ($countones(isr_o & ~$past(isr_o)) == 1));  // R4

    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && auto_eoi_i && !cmd_valid_i) |=> (isr_o == $past(isr_o)));  // R5

    AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i[1:0] == 2'b11)
        |=> !isr_o[$past(cmd_level_i)]);  // R8

    AST_SET_PRIO_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 3'b110) |=> $stable(isr_o));  // R10

endmodule

bind prio_eoi_unit prio_eoi_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ack_i       (ack_i),
    .auto_eoi_i  (auto_eoi_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .cmd_level_i (cmd_level_i),
    .win_level_o (win_level_o),
    .irq_o       (irq_o),
    .isr_o       (isr_o)
);

// File: tb/prio_eoi_unit_bench.sv
`timescale 1ns/1ps
module prio_eoi_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       ack_i = 1'b0;
    logic       auto_eoi_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_code_i = 3'b010;
    logic [2:0] cmd_level_i = '0;
    logic [2:0] win_level_o;
    logic       irq_o;
    logic [7:0] isr_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prio_eoi_unit u_prio_eoi_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .ack_i       (ack_i),
        .auto_eoi_i  (auto_eoi_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_code_i  (cmd_code_i),
        .cmd_level_i (cmd_level_i),
        .win_level_o (win_level_o),
        .irq_o       (irq_o),
        .isr_o       (isr_o)
    );

    // {rid[4], req[8], ack, cv, code[3], lvl[3], aeoi, exp_isr[8], exp_irq, exp_win[3]}
    localparam int NV = 25;
    localparam logic [32:0] VEC [NV] = '{
        {4'd2,  8'h01, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 8'h00, 1'b1, 3'd0}, // R2 idle, level 0 wins
        {4'd4,  8'h01, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0, 8'h01, 1'b0, 3'd0}, // R4 ack sets bit 0
        {4'd3,  8'h05, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 8'h01, 1'b0, 3'd0}, // R3 equal rank blocked
        {4'd3,  8'h04, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 8'h01, 1'b0, 3'd2}, // R3 lower blocked
        {4'd7,  8'h04, 1'b0, 1'b1, 3'd1, 3'd0, 1'b0, 8'h00, 1'b1, 3'd2}, // R7 EOI clears 0
        {4'd4,  8'h04, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0, 8'h04, 1'b0, 3'd2}, // R4 ack level 2
        {4'd3,  8'h06, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 8'h04, 1'b1, 3'd1}, // R3 nesting
        {4'd4,  8'h02, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0, 8'h06, 1'b0, 3'd1}, // R4 nested ack
        {4'd8,  8'h00, 1'b0, 1'b1, 3'd3, 3'd2, 1'b0, 8'h02, 1'b0, 3'd0}, // R8 specific EOI 2
        {4'd9,  8'h00, 1'b0, 1'b1, 3'd5, 3'd0, 1'b0, 8'h00, 1'b0, 3'd0}, // R9 rotating EOI
        {4'd9,  8'h0B, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 8'h00, 1'b1, 3'd3}, // R9 now 2 highest
        {4'd10, 8'h0B, 1'b0, 1'b1, 3'd6, 3'd4, 1'b0, 8'h00, 1'b1, 3'd0}, // R10 set prio 4
        {4'd4,  8'h0B, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0, 8'h01, 1'b0, 3'd0}, // R4 ack under rotation
        {4'd11, 8'h0B, 1'b0, 1'b1, 3'd7, 3'd0, 1'b0, 8'h00, 1'b1, 3'd1}, // R11 rot spec EOI 0
        {4'd5,  8'h0B, 1'b1, 1'b0, 3'd2, 3'd0, 1'b1, 8'h00, 1'b1, 3'd1}, // R5 auto EOI plain
        {4'd6,  8'h0B, 1'b0, 1'b1, 3'd4, 3'd0, 1'b1, 8'h00, 1'b1, 3'd1}, // R6 rotate mode on
        {4'd5,  8'h0B, 1'b1, 1'b0, 3'd2, 3'd0, 1'b1, 8'h00, 1'b1, 3'd3}, // R5 auto EOI rotates
        {4'd6,  8'h0B, 1'b0, 1'b1, 3'd0, 3'd0, 1'b1, 8'h00, 1'b1, 3'd3}, // R6 rotate mode off
        {4'd5,  8'h0B, 1'b1, 1'b0, 3'd2, 3'd0, 1'b1, 8'h00, 1'b1, 3'd3}, // R5 no rotate now
        {4'd6,  8'h0B, 1'b0, 1'b1, 3'd2, 3'd0, 1'b0, 8'h00, 1'b1, 3'd3}, // R6 no-op
        {4'd4,  8'h0B, 1'b1, 1'b1, 3'd2, 3'd0, 1'b0, 8'h00, 1'b1, 3'd3}, // R4 ack with strobe
        {4'd4,  8'h0B, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0, 8'h08, 1'b0, 3'd3}, // R4 ack level 3
        {4'd4,  8'h0B, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0, 8'h08, 1'b0, 3'd3}, // R4 ack, irq low
        {4'd8,  8'h0B, 1'b0, 1'b1, 3'd3, 3'd5, 1'b0, 8'h08, 1'b0, 3'd3}, // R8 unset bit
        {4'd7,  8'h0B, 1'b0, 1'b1, 3'd1, 3'd0, 1'b0, 8'h00, 1'b1, 3'd3}  // R7 EOI clears 3
    };

    task automatic chk(input string what, input int rid, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", rid, what, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] rq, input logic ak, input logic cv,
                         input logic [2:0] cd, input logic [2:0] lv, input logic ae);
        @(negedge clk);
        req_i = rq; ack_i = ak; cmd_valid_i = cv;
        cmd_code_i = cd; cmd_level_i = lv; auto_eoi_i = ae;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input int rid, input logic [7:0] ei, input logic eq, input logic [2:0] ew);
        chk("isr", rid, int'(isr_o), int'(ei));
        chk("irq", rid, int'(irq_o), int'(eq));
        chk("win", rid, int'(win_level_o), int'(ew));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: state held in reset
        #5;
        check_all(1, 8'h00, 1'b0, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][28:21], VEC[i][20], VEC[i][19], VEC[i][18:16],
                  VEC[i][15:13], VEC[i][12]);
            check_all(int'(VEC[i][32:29]), VEC[i][11:4], VEC[i][3], VEC[i][2:0]);
        end

        // R9: rotating EOI with nothing in service keeps pointer (level 2 highest)
        apply(8'h0B, 1'b0, 1'b1, 3'd5, 3'd6, 1'b0);
        check_all(9, 8'h00, 1'b1, 3'd3);

        // R7: EOI with empty in-service set is harmless
        apply(8'h0B, 1'b0, 1'b1, 3'd1, 3'd0, 1'b0);
        check_all(7, 8'h00, 1'b1, 3'd3);

        // R1: reset mid-run restores level 0 highest and plain mode
        apply(8'h0B, 1'b0, 1'b1, 3'd4, 3'd0, 1'b0);
        apply(8'h0B, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        ack_i = 1'b0;
        #1;
        check_all(1, 8'h00, 1'b1, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'h0B, 1'b1, 1'b0, 3'd2, 3'd0, 1'b1);
        check_all(1, 8'h00, 1'b1, 3'd0);

        // R12: specific EOI seen on first edge, not before
        apply(8'h80, 1'b1, 1'b0, 3'd2, 3'd0, 1'b0);
        check_all(12, 8'h80, 1'b0, 3'd7);
        @(negedge clk);
        ack_i = 1'b0; cmd_valid_i = 1'b1; cmd_code_i = 3'd3; cmd_level_i = 3'd7;
        #1;
        chk("isr before edge", 12, int'(isr_o), 8'h80);
        @(posedge clk);
        #1;
        chk("isr after edge", 12, int'(isr_o), 8'h00);

        @(negedge clk);
        cmd_valid_i = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule